// File: doc/BRIEF.md
# Serial DAC Input Front End

This block is the digital input stage of a 12-bit voltage-output converter. A host writes 16-bit words over a three-wire link: an active-low frame strobe, a serial clock and a data line. The block samples all three pins with a fast system clock through two-flop synchronisers. It finds the falling edges of the serial clock and shifts in one data bit on each, most significant bit first.

On exactly the sixteenth falling edge of a frame, the block loads the 12-bit conversion code and a 2-bit operating mode into its output registers. It also pulses an update strobe for one cycle. If the frame strobe returns high before the sixteenth edge, the block discards the partial word and leaves both registers as they were. After reset the code is zero and the mode is normal. They stay that way until the first complete frame arrives.

The serial clock idles high. The system clock must run at least four times the serial clock rate.

Top module: `dac_serial_frontend`

## Requirements
- R1: While reset is active and right after it, code_o is 0, pd_sel_o is 3'b000, pwr_dn_o is 0 and upd_o is 0.
- R2: Data bits are captured most significant bit first, one per falling edge of the synchronised serial clock, and only while the synchronised frame strobe is low.
- R3: A frame with 16 falling edges loads word bits 11:0 into code_o.
- R4: Word bits 13:12 pick the mode. 2'b00 is normal: pd_sel_o is 0 and pwr_dn_o is 0. 2'b01 sets pd_sel_o[0], 2'b10 sets pd_sel_o[1] and 2'b11 sets pd_sel_o[2]; each of these also drives pwr_dn_o high. Word bits 15:14 have no effect.
- R5: If the frame strobe rises before the 16th falling edge, code_o and the mode stay unchanged and upd_o does not pulse.
- R6: Falling edges after the 16th within the same low period of the frame strobe are ignored. A new frame starts only after the strobe goes high and then low again.
- R7: upd_o pulses high for one cycle, in the same cycle that new code and mode values first appear. It never pulses otherwise.
- R8: After reset, code_o stays 0 through any partial frames until the first complete frame.
- R9: Serial clock edges while the frame strobe is high shift nothing and do not affect the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsync_ni | input | 1 | Frame strobe, active low |
| sclk_i | input | 1 | Serial clock, idles high, data taken on falling edge |
| sdata_i | input | 1 | Serial data |
| code_o | output | 12 | Conversion code to the analog core |
| pd_sel_o | output | 3 | Power-down output termination select, at most one bit high |
| pwr_dn_o | output | 1 | Analog core power-down |
| upd_o | output | 1 | One-cycle strobe when code and mode load |

## Verification
The hardest cases to reach are the two edge-count boundaries. One is a frame cut off after fifteen edges, one short of a load. The other is a frame that keeps clocking past sixteen, where the extra bits must not leak into the stored word.

The frame driver task takes an edge count as well as a word. The stimulus therefore sends frames of 10, 15, 16 and 20 falling edges, plus clock toggling while the strobe is high. The scoreboard expects an update only when at least sixteen edges were sent. Any unexpected strobe counts as a failure.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int CODE_W   = 12;
  localparam int FRAME_W  = 16;
  localparam int MODE_LSB = 12;
  localparam int MODE_W   = 2;
  localparam int PD_W     = (1 << MODE_W) - 1;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN  = 2'b00,
    MODE_PD_A = 2'b01,
    MODE_PD_B = 2'b10,
    MODE_PD_C = 2'b11
  } mode_e;
endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/dac_fe_shifter.sv
module dac_fe_shifter #(
  parameter int FRAME_W = 16,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fsync_s_i,
  input  logic               sclk_s_i,
  input  logic               sdata_s_i,
  output logic               done_o,
  output logic [FRAME_W-1:0] word_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic               sclk_q;
  logic               armed_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q, sh_nxt;
  logic               fall;

  assign fall   = sclk_q & ~sclk_s_i;
  assign sh_nxt = {sh_q[FRAME_W-2:0], sdata_s_i};
  assign done_o = ~fsync_s_i & fall & armed_q & (cnt_q == LAST);
  assign word_o = sh_nxt;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      if (fsync_s_i) begin
        // strobe high re-arms for the next frame
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (fall && armed_q) begin
        sh_q <= sh_nxt;
        if (cnt_q == LAST) begin
          armed_q <= 1'b0;
          cnt_q   <= FULL;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dac_fe_regs.sv
module dac_fe_regs
  import dac_fe_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [CODE_W-1:0]  code_o,
  output logic [PD_W-1:0]    pd_sel_o,
  output logic               pwr_dn_o,
  output logic               upd_o
);
  mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      mode_q <= MODE_RUN;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= load_i;
      if (load_i) begin
        code_o <= word_i[CODE_W-1:0];
        mode_q <= mode_e'(word_i[MODE_LSB +: MODE_W]);
      end
    end
  end

  for (genvar k = 0; k < PD_W; k++) begin : g_pd
    assign pd_sel_o[k] = (mode_q == mode_e'(k + 1));
  end

  assign pwr_dn_o = (mode_q != MODE_RUN);
endmodule

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend
  import dac_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic [PD_W-1:0]   pd_sel_o,
  output logic              pwr_dn_o,
  output logic              upd_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [2:0]         pins_s;
  logic               fsync_s, sclk_s, sdata_s;
  logic               done;
  logic [FRAME_W-1:0] word;
  logic [CNT_W-1:0]   cnt;

  dac_fe_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdata_i, sclk_i, fsync_ni}),
    .q_o   (pins_s)
  );

  assign fsync_s = pins_s[0];
  assign sclk_s  = pins_s[1];
  assign sdata_s = pins_s[2];

  dac_fe_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fsync_s_i(fsync_s),
    .sclk_s_i (sclk_s),
    .sdata_s_i(sdata_s),
    .done_o   (done),
    .word_o   (word),
    .cnt_o    (cnt)
  );

  dac_fe_regs #(.FRAME_W(FRAME_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (done),
    .word_i  (word),
    .code_o  (code_o),
    .pd_sel_o(pd_sel_o),
    .pwr_dn_o(pwr_dn_o),
    .upd_o   (upd_o)
  );
endmodule

// File: rtl/dac_fe_checker.sv
module dac_fe_checker #(
  parameter int CODE_W  = 12,
  parameter int PD_W    = 3,
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fsync_s_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CODE_W-1:0] code_i,
  input logic [PD_W-1:0]   pd_sel_i,
  input logic              pwr_dn_i,
  input logic              upd_i
);
  // R7
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !upd_i);
  // R7, R5
  a_r7_hold_without_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |-> ($stable(code_i) && $stable(pd_sel_i)));
  // R4
  a_r4_pd_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pd_sel_i));
  // R4
  a_r4_pwr_dn_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pd_sel_i) == (pwr_dn_i ? 1 : 0));
  // R5
  a_r5_upd_needs_low_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> !$past(fsync_s_i));
  // R9
  a_r9_high_strobe_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_s_i |=> (cnt_i == '0));
  // R6
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(FRAME_W));
endmodule

bind dac_serial_frontend dac_fe_checker #(
  .CODE_W (CODE_W),
  .PD_W   (PD_W),
  .FRAME_W(FRAME_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .fsync_s_i(fsync_s),
  .cnt_i    (cnt),
  .code_i   (code_o),
  .pd_sel_i (pd_sel_o),
  .pwr_dn_i (pwr_dn_o),
  .upd_i    (upd_o)
);

// File: tb/dac_serial_frontend_tb_top.sv
module dac_serial_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fsync_ni = 1'b1;
  logic        sclk_i = 1'b1;
  logic        sdata_i = 1'b0;
  logic [11:0] code_o;
  logic [2:0]  pd_sel_o;
  logic        pwr_dn_o;
  logic        upd_o;

  int n_chk = 0;
  int n_err = 0;
  int n_upd = 0;
  int n_exp = 0;
  logic upd_prev = 1'b0;
  logic [14:0] exp_q[$];

  always #4 clk = ~clk;

  dac_serial_frontend dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .fsync_ni(fsync_ni), .sclk_i(sclk_i),
    .sdata_i(sdata_i), .code_o(code_o), .pd_sel_o(pd_sel_o),
    .pwr_dn_o(pwr_dn_o), .upd_o(upd_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] pd_of(input logic [1:0] m);
    case (m)
      2'b01:   return 3'b001;
      2'b10:   return 3'b010;
      2'b11:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: nedge falling edges; expectation pushed only for complete frames
  task automatic send(input logic [15:0] w, input int nedge);
    if (nedge >= 16) begin
      exp_q.push_back({pd_of(w[13:12]), w[11:0]});
      n_exp++;
    end
    @(negedge clk);
    fsync_ni = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nedge; i++) begin
      sdata_i = (i < 16) ? w[15-i] : ~w[0];
      wait_clk(4);
      sclk_i = 1'b0;
      wait_clk(4);
      sclk_i = 1'b1;
    end
    wait_clk(4);
    fsync_ni = 1'b1;
    wait_clk(12);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (upd_o && upd_prev) check("R7 pulse width", 32'd2, 32'd1);
      if (upd_o) begin
        n_upd++;
        if (exp_q.size() == 0) begin
          check("R5/R6 unexpected update", 32'd1, 32'd0);
        end else begin
          logic [14:0] e;
          e = exp_q.pop_front();
          check("R3 code", 32'(code_o), 32'(e[11:0]));
          check("R4 pd_sel", 32'(pd_sel_o), 32'(e[14:12]));
          check("R4 pwr_dn", 32'(pwr_dn_o), 32'(e[14:12] != 3'b000));
        end
      end
      upd_prev = upd_o;
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    wait_clk(3);
    // R1 during reset
    check("R1 code in reset", 32'(code_o), 32'd0);
    check("R1 upd in reset", 32'(upd_o), 32'd0);
    rst_ni = 1'b1;
    wait_clk(4);
    check("R1 code", 32'(code_o), 32'd0);
    check("R1 pd_sel", 32'(pd_sel_o), 32'd0);
    check("R1 pwr_dn", 32'(pwr_dn_o), 32'd0);
    check("R1 upd", 32'(upd_o), 32'd0);

    // R8 / R5: partial frames after reset leave code at zero
    send(16'h3ABC, 10);
    check("R8 code after partial", 32'(code_o), 32'd0);
    send(16'h1FFF, 15);
    check("R5 code after 15 edges", 32'(code_o), 32'd0);
    check("R5 pwr_dn after 15 edges", 32'(pwr_dn_o), 32'd0);

    // R9: clock toggles with strobe high
    for (int i = 0; i < 5; i++) begin
      sdata_i = 1'b1;
      wait_clk(4); sclk_i = 1'b0;
      wait_clk(4); sclk_i = 1'b1;
    end
    send(16'h0ABC, 16);
    check("R9 R3 code after idle toggles", 32'(code_o), 32'h0ABC);

    // R4: modes, with don't-care bits set
    send(16'hD123, 16);
    check("R4 mode 01", 32'(pd_sel_o), 32'b001);
    send(16'h6456, 16);
    check("R4 mode 10", 32'(pd_sel_o), 32'b010);
    send(16'hF789, 16);
    check("R4 mode 11", 32'(pd_sel_o), 32'b100);
    check("R4 pwr_dn mode 11", 32'(pwr_dn_o), 32'd1);

    // R2 / R3: boundaries, return to normal
    send(16'hCFFF, 16);
    check("R2 code all ones", 32'(code_o), 32'hFFF);
    check("R4 back to normal", 32'(pwr_dn_o), 32'd0);
    send(16'h0001, 16);
    check("R2 code lsb only", 32'(code_o), 32'h001);
    send(16'h0800, 16);
    check("R2 code msb only", 32'(code_o), 32'h800);

    // R5: 15 edges with new mode, nothing changes
    send(16'h3555, 15);
    check("R5 code held", 32'(code_o), 32'h800);
    check("R5 mode held", 32'(pd_sel_o), 32'd0);

    // R6: extra edges after the 16th ignored
    send(16'h2A5A, 20);
    check("R6 code with extra edges", 32'(code_o), 32'hA5A);
    check("R6 mode with extra edges", 32'(pd_sel_o), 32'b010);
    send(16'h0333, 16);
    check("R6 next frame after strobe cycle", 32'(code_o), 32'h333);

    wait_clk(10);
    check("R7 update count", 32'(n_upd), 32'(n_exp));
    check("R7 queue drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule